// File: doc/BRIEF.md
# Parallel FPGA Configuration Sequencer

This block drives the configuration port of a downstream FPGA from a byte stream. A one-cycle start pulse launches a run. The block first holds the device's active-low program line low for a minimum time. It then waits for the device's active-low status line to fall, releases the program line, and waits for the status line to rise again. Next it enables the parallel port with active-low select and write strobes and lets the port settle. It then moves one byte per configuration clock cycle from a valid/ready input stream onto the 8-bit port. When the last byte is written it closes the port and waits for the device's finished flag.

Every wait has a limit counted in system clock cycles. A single shared down-counter serves all the limits and is reloaded on entry to each wait. Any timeout, and any drop of the status line during the data phase, sends the machine through an abort state. The abort state releases the port. The run then ends with a sticky fail flag and a code naming the cause. A clean run ends with a sticky success flag. The byte count is taken from `byte_cnt_i` at start.

States: `ST_IDLE` goes to `ST_PROG_HOLD` on start. `ST_PROG_HOLD` goes to `ST_WAIT_INIT_LO` when the minimum low time is spent. `ST_WAIT_INIT_LO` goes to `ST_WAIT_INIT_HI` on status low, or to `ST_ABORT` on timeout. `ST_WAIT_INIT_HI` goes to `ST_SETTLE` on status high, or to `ST_ABORT` on timeout. `ST_SETTLE` goes to `ST_LOAD`, or to `ST_END_CS` when the count is zero. `ST_LOAD` goes to `ST_CLK_LO` on a byte handshake, or to `ST_ABORT` on status low. `ST_CLK_LO` goes to `ST_CLK_HI`. `ST_CLK_HI` goes to `ST_WAIT_BUSY` when hold checking is enabled; otherwise it goes to `ST_LOAD` or `ST_END_CS`. `ST_WAIT_BUSY` goes to `ST_LOAD` or `ST_END_CS` when hold clears, or to `ST_ABORT` on timeout. `ST_END_CS` goes to `ST_END_WR`, then `ST_WAIT_DONE`. `ST_WAIT_DONE` goes to `ST_IDLE` on success, or to `ST_ABORT` on timeout. `ST_ABORT` goes to `ST_IDLE`.

Top module: `pcfg_loader`

## Requirements
- R1: After reset, cfg_rst_n_o, cfg_sel_n_o, cfg_wr_n_o and cfg_clk_o are high. run_o, ok_o, fail_o and s_ready_o are low.
- R2: A start pulse in idle clears ok_o and fail_o and raises run_o. It drives cfg_rst_n_o low for at least PROG_LOW_CYC cycles and keeps it low until cfg_stat_n_i is seen low. A start pulse during a run is ignored and does not reload the byte count.
- R3: If cfg_stat_n_i does not fall within INIT_TMO_CYC cycles after the minimum low time, the run aborts with fail code 1, and the port is never enabled.
- R4: After cfg_rst_n_o is released, if cfg_stat_n_i does not rise within INIT_TMO_CYC cycles, the run aborts with fail code 2.
- R5: When cfg_stat_n_i rises, cfg_sel_n_o and cfg_wr_n_o go low. At least SETTLE_CYC cycles pass before s_ready_o first rises.
- R6: s_ready_o is high only in the load state with cfg_stat_n_i high. Each accepted byte appears on cfg_d_o and is followed by one cfg_clk_o low cycle and one high cycle. cfg_d_o is stable across the rising edge. Exactly the latched count of bytes is consumed, in stream order, whatever the gaps in s_valid_i.
- R7: cfg_stat_n_i low in the load state aborts with fail code 3. No further byte is consumed, even when a byte is offered in that cycle.
- R8: With USE_BUSY set, after each rising cfg_clk_o the block waits for cfg_hold_i low. If it stays high beyond BUSY_TMO_CYC cycles, the run aborts with fail code 4.
- R9: After the last byte, cfg_sel_n_o rises exactly one cycle before cfg_wr_n_o.
- R10: Success requires cfg_fin_i and cfg_stat_n_i high in the same cycle. cfg_fin_i alone never yields ok_o.
- R11: If success is not seen within DONE_TMO_CYC cycles, the run aborts with fail code 5.
- R12: An abort releases cfg_sel_n_o and cfg_wr_n_o and ends the run. fail_o is never set without a nonzero code. fail_o and its code stay until the next start.
- R13: A byte count of zero skips the data phase: no byte is taken, no configuration clock is given, and the run can still succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle run request |
| byte_cnt_i | input | CNT_W | Number of bytes, latched at start |
| s_data_i | input | DATA_W | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| cfg_rst_n_o | output | 1 | Device program line, active low |
| cfg_stat_n_i | input | 1 | Device status line, low while clearing or on error |
| cfg_sel_n_o | output | 1 | Port select, active low |
| cfg_wr_n_o | output | 1 | Port write strobe, active low |
| cfg_clk_o | output | 1 | Configuration clock, byte taken on its rise |
| cfg_d_o | output | DATA_W | Configuration data bus |
| cfg_hold_i | input | 1 | Device hold request |
| cfg_fin_i | input | 1 | Device finished flag |
| run_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run succeeded (sticky) |
| fail_o | output | 1 | Last run failed (sticky) |
| fail_code_o | output | 3 | Cause of last failure, 0 when none |

## Verification
Two events can land in one cycle: a stream byte offered in the load state, and the device's status line falling. The bench provokes this by dropping the status line at the rising configuration clock of a chosen byte, with hold pulses active and the next byte already valid. As a result, the load state is entered with a byte offered and the line already low. The scoreboard must then show that exactly the earlier bytes were captured, that the offered byte never reached the bus, and that the run ends with code 3. The same timing is used at the end of a run, where the finished flag rises while the status line falls; that run must end with code 5, not success.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int FC_W = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_HOLD,
        ST_WAIT_INIT_LO,
        ST_WAIT_INIT_HI,
        ST_SETTLE,
        ST_LOAD,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_WAIT_BUSY,
        ST_END_CS,
        ST_END_WR,
        ST_WAIT_DONE,
        ST_ABORT
    } pcfg_state_e;

    typedef enum logic [FC_W-1:0] {
        FC_NONE        = 3'd0,
        FC_STAT_NO_LO  = 3'd1,
        FC_STAT_NO_HI  = 3'd2,
        FC_STAT_ERR    = 3'd3,
        FC_HOLD_TMO    = 3'd4,
        FC_FIN_TMO     = 3'd5
    } pcfg_fail_e;

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o); // R3

endmodule

// File: rtl/pcfg_bytecnt.sv
module pcfg_bytecnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o,
    output logic             one_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= load_val_i;
        end else if (dec_i) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign zero_o = (rem_q == '0);
    assign one_o  = (rem_q == ONE);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> !zero_o); // R6

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
    import pcfg_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CNT_W         = 16,
    parameter int TMR_W         = 32,
    parameter int PROG_LOW_CYC  = 60,
    parameter int INIT_TMO_CYC  = 100_000_000,
    parameter int SETTLE_CYC    = 2_000_000,
    parameter int BUSY_TMO_CYC  = 1_000_000,
    parameter int DONE_TMO_CYC  = 40_000_000,
    parameter bit USE_BUSY      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    output logic              cfg_rst_n_o,
    input  logic              cfg_stat_n_i,
    output logic              cfg_sel_n_o,
    output logic              cfg_wr_n_o,
    output logic              cfg_clk_o,
    output logic [DATA_W-1:0] cfg_d_o,
    input  logic              cfg_hold_i,
    input  logic              cfg_fin_i,
    output logic              run_o,
    output logic              ok_o,
    output logic              fail_o,
    output logic [2:0]        fail_code_o
);

    localparam logic [TMR_W-1:0] LD_PROG   = TMR_W'(PROG_LOW_CYC - 1);
    localparam logic [TMR_W-1:0] LD_INIT   = TMR_W'(INIT_TMO_CYC);
    localparam logic [TMR_W-1:0] LD_SETTLE = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_BUSY   = TMR_W'(BUSY_TMO_CYC);
    localparam logic [TMR_W-1:0] LD_DONE   = TMR_W'(DONE_TMO_CYC);

    pcfg_state_e       state_q, state_d;
    pcfg_fail_e        code_q, abort_code;
    logic [DATA_W-1:0] d_q;
    logic              ok_q, fail_q;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              bc_load, bc_dec, bc_zero, bc_one;
    logic              take, go_ok, hold_seen;

    generate
        if (USE_BUSY) begin : g_hold
            assign hold_seen = cfg_hold_i;
        end else begin : g_nohold
            assign hold_seen = 1'b0;
        end
    endgenerate

    pcfg_timer #(.TMR_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    pcfg_bytecnt #(.CNT_W(CNT_W)) u_bytecnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (bc_load),
        .load_val_i (byte_cnt_i),
        .dec_i      (bc_dec),
        .zero_o     (bc_zero),
        .one_o      (bc_one)
    );

    // next state, timer reloads and byte-counter control
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        bc_load    = 1'b0;
        bc_dec     = 1'b0;
        take       = 1'b0;
        go_ok      = 1'b0;
        abort_code = FC_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_PROG_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PROG;
                    bc_load  = 1'b1;
                end
            end
            ST_PROG_HOLD: begin
                if (tmr_exp) begin
                    state_d  = ST_WAIT_INIT_LO;
                    tmr_load = 1'b1;
                    tmr_val  = LD_INIT;
                end
            end
            ST_WAIT_INIT_LO: begin
                if (!cfg_stat_n_i) begin
                    state_d  = ST_WAIT_INIT_HI;
                    tmr_load = 1'b1;
                    tmr_val  = LD_INIT;
                end else if (tmr_exp) begin
                    state_d    = ST_ABORT;
                    abort_code = FC_STAT_NO_LO;
                end
            end
            ST_WAIT_INIT_HI: begin
                if (cfg_stat_n_i) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETTLE;
                end else if (tmr_exp) begin
                    state_d    = ST_ABORT;
                    abort_code = FC_STAT_NO_HI;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    state_d = bc_zero ? ST_END_CS : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!cfg_stat_n_i) begin
                    state_d    = ST_ABORT;
                    abort_code = FC_STAT_ERR;
                end else if (s_valid_i) begin
                    take    = 1'b1;
                    state_d = ST_CLK_LO;
                end
            end
            ST_CLK_LO: begin
                state_d = ST_CLK_HI;
            end
            ST_CLK_HI: begin
                bc_dec = 1'b1;
                if (USE_BUSY) begin
                    state_d  = ST_WAIT_BUSY;
                    tmr_load = 1'b1;
                    tmr_val  = LD_BUSY;
                end else begin
                    state_d = bc_one ? ST_END_CS : ST_LOAD;
                end
            end
            ST_WAIT_BUSY: begin
                if (!hold_seen) begin
                    state_d = bc_zero ? ST_END_CS : ST_LOAD;
                end else if (tmr_exp) begin
                    state_d    = ST_ABORT;
                    abort_code = FC_HOLD_TMO;
                end
            end
            ST_END_CS: begin
                state_d = ST_END_WR;
            end
            ST_END_WR: begin
                state_d  = ST_WAIT_DONE;
                tmr_load = 1'b1;
                tmr_val  = LD_DONE;
            end
            ST_WAIT_DONE: begin
                if (cfg_fin_i && cfg_stat_n_i) begin
                    state_d = ST_IDLE;
                    go_ok   = 1'b1;
                end else if (tmr_exp) begin
                    state_d    = ST_ABORT;
                    abort_code = FC_FIN_TMO;
                end
            end
            ST_ABORT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register, data latch and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            d_q     <= '0;
            ok_q    <= 1'b0;
            fail_q  <= 1'b0;
            code_q  <= FC_NONE;
        end else begin
            state_q <= state_d;
            if (take) begin
                d_q <= s_data_i;
            end
            if (state_q == ST_IDLE && start_i) begin
                ok_q   <= 1'b0;
                fail_q <= 1'b0;
                code_q <= FC_NONE;
            end else if (go_ok) begin
                ok_q <= 1'b1;
            end else if (state_d == ST_ABORT && state_q != ST_ABORT) begin
                fail_q <= 1'b1;
                code_q <= abort_code;
            end
        end
    end

    // port drive decoded from state
    always_comb begin
        cfg_rst_n_o = 1'b1;
        cfg_sel_n_o = 1'b1;
        cfg_wr_n_o  = 1'b1;
        cfg_clk_o   = 1'b1;
        s_ready_o   = 1'b0;
        unique case (state_q)
            ST_PROG_HOLD, ST_WAIT_INIT_LO: begin
                cfg_rst_n_o = 1'b0;
            end
            ST_SETTLE, ST_CLK_HI, ST_WAIT_BUSY: begin
                cfg_sel_n_o = 1'b0;
                cfg_wr_n_o  = 1'b0;
            end
            ST_LOAD: begin
                cfg_sel_n_o = 1'b0;
                cfg_wr_n_o  = 1'b0;
                s_ready_o   = cfg_stat_n_i;
            end
            ST_CLK_LO: begin
                cfg_sel_n_o = 1'b0;
                cfg_wr_n_o  = 1'b0;
                cfg_clk_o   = 1'b0;
            end
            ST_END_CS: begin
                cfg_wr_n_o = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign cfg_d_o     = d_q;
    assign run_o       = (state_q != ST_IDLE);
    assign ok_o        = ok_q;
    assign fail_o      = fail_q;
    assign fail_code_o = code_q;

    AST_READY_PORT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (!cfg_sel_n_o && !cfg_wr_n_o && cfg_rst_n_o && cfg_stat_n_i)); // R6
    AST_CLK_LOW_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_clk_o |-> (!cfg_sel_n_o && !cfg_wr_n_o)); // R6
    AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk_o) |-> $stable(cfg_d_o)); // R6
    AST_PROG_PORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n_o |-> (cfg_sel_n_o && cfg_wr_n_o)); // R2
    AST_SEL_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr_n_o) |-> cfg_sel_n_o); // R9
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && fail_o)); // R10
    AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (fail_code_o != 3'd0)); // R12
    AST_IDLE_PORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> (cfg_sel_n_o && cfg_wr_n_o && cfg_rst_n_o && cfg_clk_o)); // R12

endmodule

// File: tb/pcfg_loader_tb_top.sv
`timescale 1ns/1ps
module pcfg_loader_tb_top;

    localparam int PLOW   = 4;
    localparam int ITMO   = 20;
    localparam int SETTLE = 6;
    localparam int BTMO   = 10;
    localparam int DTMO   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cnt_in = '0;
    logic [7:0] sd = '0;
    logic       sv = 1'b0;
    logic       init_b = 1'b1;
    logic       busy = 1'b0;
    logic       done = 1'b0;

    logic       s_ready, prog_n, sel_n, wr_n, cclk, run, ok, fail;
    logic [7:0] dbus;
    logic [2:0] code;

    always #2.5 clk = ~clk;

    pcfg_loader #(
        .DATA_W(8), .CNT_W(8), .TMR_W(16),
        .PROG_LOW_CYC(PLOW), .INIT_TMO_CYC(ITMO), .SETTLE_CYC(SETTLE),
        .BUSY_TMO_CYC(BTMO), .DONE_TMO_CYC(DTMO), .USE_BUSY(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_cnt_i(cnt_in),
        .s_data_i(sd), .s_valid_i(sv), .s_ready_o(s_ready),
        .cfg_rst_n_o(prog_n), .cfg_stat_n_i(init_b), .cfg_sel_n_o(sel_n),
        .cfg_wr_n_o(wr_n), .cfg_clk_o(cclk), .cfg_d_o(dbus),
        .cfg_hold_i(busy), .cfg_fin_i(done), .run_o(run), .ok_o(ok),
        .fail_o(fail), .fail_code_o(code)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] expq[$];
    int popped = 0;

    // device model controls
    bit m_stuck_hi = 0, m_stuck_lo = 0, m_busy_stuck = 0, m_no_done = 0, m_done_init_lo = 0;
    int m_err_at = 0;
    int dev_rises = 0, lo_cnt = 0, hi_cnt = 0, busy_cnt = 0;
    bit err_lat = 0;

    // monitor state
    logic prev_cclk = 1'b1, prev_prog = 1'b1, prev_sel = 1'b1, prev_wr = 1'b1;
    int prog_len = 0, last_prog_w = 0;
    int sel_fall_cyc = -1, first_rdy_cyc = -1, sel_rise_cyc = -1, wr_rise_cyc = -1;

    task automatic chk(input bit c, input string what, input longint act, input longint exp);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(8'h5A ^ (i * 37 + 3));
    endfunction

    // scoreboard monitor, then device model
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cclk && !prev_cclk) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R6 capture without accepted byte", dbus, 0);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    chk(dbus == e, "R6 byte on rising config clock", dbus, e);
                    popped++;
                end
            end
            if (!prog_n) prog_len++;
            else begin
                if (!prev_prog) last_prog_w = prog_len;
                prog_len = 0;
            end
            if (!sel_n && prev_sel) sel_fall_cyc = cyc;
            if (sel_n && !prev_sel) sel_rise_cyc = cyc;
            if (wr_n && !prev_wr) wr_rise_cyc = cyc;
            if (s_ready && first_rdy_cyc < 0) first_rdy_cyc = cyc;

            if (cclk && !prev_cclk) begin
                dev_rises++;
                busy = 1'b1;
                busy_cnt = 2;
                if (dev_rises == m_err_at) begin
                    init_b = 1'b0;
                    err_lat = 1'b1;
                end
            end else if (busy && !m_busy_stuck) begin
                if (busy_cnt > 0) busy_cnt--;
                if (busy_cnt == 0) busy = 1'b0;
            end
            if (!prog_n) begin
                err_lat = 1'b0;
                done = 1'b0;
                hi_cnt = 0;
                if (!m_stuck_hi) begin
                    lo_cnt++;
                    if (lo_cnt >= 3) init_b = 1'b0;
                end
            end else begin
                lo_cnt = 0;
                if (!init_b && !m_stuck_lo && !err_lat) begin
                    hi_cnt++;
                    if (hi_cnt >= 3) begin
                        init_b = 1'b1;
                        hi_cnt = 0;
                    end
                end
            end
            if (wr_n && !prev_wr) begin
                if (!m_no_done) done = 1'b1;
                if (m_done_init_lo) begin
                    init_b = 1'b0;
                    err_lat = 1'b1;
                end
            end
        end
        prev_cclk = cclk;
        prev_prog = prog_n;
        prev_sel  = sel_n;
        prev_wr   = wr_n;
    end

    // stream driver: pushes every byte it sees accepted
    task automatic feed(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            bit got;
            got = 1'b0;
            sv = 1'b1;
            sd = pat(i);
            while (!got && run) begin
                if (s_ready) begin
                    got = 1'b1;
                    expq.push_back(sd);
                end else begin
                    @(negedge clk);
                end
            end
            if (!got) break;
            @(negedge clk);
            sv = 1'b0;
            repeat (gap) @(negedge clk);
        end
        sv = 1'b0;
    endtask

    task automatic run_cfg(input int n_cnt, input int n_feed, input int gap, input bit exp_ok,
                           input int exp_code, input int exp_bytes, input bit spur, input string tag);
        expq.delete();
        popped = 0;
        dev_rises = 0;
        sel_fall_cyc = -1; first_rdy_cyc = -1; sel_rise_cyc = -1; wr_rise_cyc = -1;
        last_prog_w = 0;
        @(negedge clk);
        cnt_in = 8'(n_cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(run && !ok && !fail, {"R2 start accepted and status cleared ", tag}, {ok, fail}, 0);
        fork
            feed(n_feed, gap);
        join_none
        if (spur) begin
            repeat (20) @(negedge clk);
            cnt_in = 8'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (run) @(negedge clk);
        wait fork;
        chk(ok == exp_ok, {"R10 ok flag ", tag}, ok, exp_ok);
        chk(fail == !exp_ok, {"R12 fail flag ", tag}, fail, !exp_ok);
        chk(code == 3'(exp_code), {"R12 fail code ", tag}, code, exp_code);
        chk(popped == exp_bytes, {"R6 bytes captured ", tag}, popped, exp_bytes);
        chk(expq.size() == 0, {"R7 no accepted byte left uncaptured ", tag}, expq.size(), 0);
        chk(last_prog_w >= PLOW, {"R2 program low width ", tag}, last_prog_w, PLOW);
        chk(sel_n && wr_n && prog_n, {"R12 port released at end ", tag}, {sel_n, wr_n, prog_n}, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(prog_n && sel_n && wr_n && cclk, "R1 port lines idle in reset", {prog_n, sel_n, wr_n, cclk}, 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!run && !ok && !fail && !s_ready, "R1 status idle after reset", {run, ok, fail, s_ready}, 0);

        // plain run with hold pulses
        run_cfg(5, 5, 0, 1, 0, 5, 0, "basic");
        chk(first_rdy_cyc - sel_fall_cyc >= SETTLE, "R5 settle before first ready", first_rdy_cyc - sel_fall_cyc, SETTLE);
        chk(wr_rise_cyc - sel_rise_cyc == 1, "R9 select released one cycle before write", wr_rise_cyc - sel_rise_cyc, 1);
        chk(dev_rises == 5, "R8 one clock per byte with hold", dev_rises, 5);

        // stream with gaps
        run_cfg(7, 7, 2, 1, 0, 7, 0, "gaps");
        chk(wr_rise_cyc - sel_rise_cyc == 1, "R9 order with gaps", wr_rise_cyc - sel_rise_cyc, 1);

        // start during run must not reload count
        run_cfg(6, 6, 1, 1, 0, 6, 1, "spurious start R2");

        // status never falls
        m_stuck_hi = 1;
        run_cfg(4, 4, 0, 0, 1, 0, 0, "R3");
        chk(sel_fall_cyc == -1, "R3 port never enabled", sel_fall_cyc, -1);
        m_stuck_hi = 0;

        // status never rises
        m_stuck_lo = 1;
        run_cfg(4, 4, 0, 0, 2, 0, 0, "R4");
        m_stuck_lo = 0;
        repeat (5) @(negedge clk);

        // status drops at third byte while next byte is offered
        m_err_at = 3;
        run_cfg(6, 6, 0, 0, 3, 3, 0, "R7");
        m_err_at = 0;

        // hold stuck after first byte
        m_busy_stuck = 1;
        run_cfg(4, 4, 0, 0, 4, 1, 0, "R8");
        m_busy_stuck = 0;
        repeat (5) @(negedge clk);

        // finished never seen
        m_no_done = 1;
        run_cfg(3, 3, 0, 0, 5, 3, 0, "R11");
        m_no_done = 0;
        repeat (5) @(negedge clk);
        chk(fail && code == 3'd5, "R12 failure is sticky", {fail, code}, 13);

        // finished rises while status falls
        m_done_init_lo = 1;
        run_cfg(2, 2, 0, 0, 5, 2, 0, "R10 finished without status");
        m_done_init_lo = 0;

        // zero byte run
        run_cfg(0, 0, 0, 1, 0, 0, 0, "R13");
        chk(dev_rises == 0, "R13 no configuration clock", dev_rises, 0);

        run_cfg(3, 3, 0, 1, 0, 3, 0, "recovery");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule